// File: doc/BRIEF.md
# Register-Mapped Digital Output Router

This block holds the control registers for a ten-channel high-voltage digital output port and works out the level on each output pin. Every channel has an 8-bit selector that picks one line of a 256-line internal signal bus. A per-channel bypass mask can replace that routed line with a value that software writes. The first eight channels share a global enable. They also have a two-bit mode each, which sets push-pull or high-side drive and turns open-load detection on or off. A global push-pull flag overrides all of these mode bits.

The external driver reports a 16-bit status word, with one fault flag and one state flag per gated channel. The block decodes this word per channel and software can read it back. The block presents the mode word to the driver as parallel vectors and does not serialize it.

Software reaches the registers over a plain address/data bus with one write strobe and one read strobe. There is no stream traffic and no back-pressure: the block accepts a strobe in every cycle in which it is high. Read data is registered. It shows on `bus_rdata` one clock after the read strobe and holds until the next read.

Top module: `dor_router`

## Requirements
- R1: Each write to addresses 0..9 stores `bus_wdata[7:0]` as the selector of channel 0..9. An unmasked channel then drives `sig_bus[selector]`, starting the cycle after the write edge, and it follows later changes of `sig_bus`.
- R2: Address 16 is read/write. Bits 9..0 hold the software values of channels 9..0 and bits 25..16 hold their bypass mask. A mask bit of 1 makes the channel drive its software bit. Other bits of address 16 read back as 0.
- R3: Bit 0 of address 19 is the output enable for channels 0..7. While it is 0, `chan_out[7:0]` is 0. Channels 8 and 9 never depend on it, and `drv_enable` mirrors it.
- R4: Address 18 is a read/write 16-bit mode word. Bit k is the push-pull bit of channel k and bit k+8 is the open-load bit of channel k, for k in 0..7. `drv_pushpull[k]` equals bit k. `drv_openload[k]` equals bit k+8 when the channel is not push-pull, and is 0 otherwise.
- R5: Bit 3 of address 19 is the global push-pull flag. While it is 1, `drv_pushpull` is all ones and `drv_openload` is 0, and address 18 still reads back its stored value.
- R6: A read of address 19 returns the stored bits 3 and 0. Bit 1 (serial mode) reads back as 0, and bit 2 and bits 31..4 read back as 0.
- R7: A read of address 17 returns `drv_status` in bits 15..0. Channel k has its fault flag at bit k+8 and its state flag at bit k. `stat_undef[k]` is fault AND NOT state, and `stat_uvlo[k]` is fault AND state. A write to address 17 changes no register.
- R8: A read of address 0 returns the version byte 0x5C in bits 7..0. Reads of addresses 1..15 and 20..31 return 0.
- R9: `bus_rdata` loads on each clock edge where `bus_rd` is 1 and otherwise holds its value. If a read and a write hit the same address in one cycle, the read returns the old value.
- R10: After reset every register is 0. `bus_rdata` is 0, `chan_out[7:0]` is 0, `chan_out[9:8]` both follow `sig_bus[0]`, and `drv_pushpull`, `drv_openload` and `drv_enable` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| sig_bus | input | 256 | Internal signal lines for routing |
| drv_status | input | 16 | Fault/state word from the driver |
| chan_out | output | 10 | Output channel levels |
| drv_pushpull | output | 8 | Effective push-pull select, channels 0..7 |
| drv_openload | output | 8 | Effective open-load detect enable, channels 0..7 |
| drv_enable | output | 1 | Global enable for channels 0..7 |
| stat_undef | output | 8 | Fault with undefined level, per channel |
| stat_uvlo | output | 8 | Undervoltage lockout, per channel |

## Verification
A corrupted selector register shows up on `chan_out` in the very next cycle, but only when the signal line it wrongly selects differs from the intended one. The bench therefore uses an irregular `sig_bus` pattern and also checks the inverted pattern. A lost mask, enable or mode bit changes `chan_out` or the driver vectors as soon as the register edge has passed. Read-back faults appear one clock after the read strobe, so each value is checked both at the driver pins and through a read.

// File: rtl/dor_pkg.sv
package dor_pkg;
  localparam int AW        = 5;
  localparam int DW        = 32;
  localparam int NCH       = 10;
  localparam int NGATED    = 8;
  localparam int SELW      = 8;
  localparam int BUSW      = 1 << SELW;
  localparam int MASK_LSB  = 16;
  localparam int ADDR_CFG  = 16;
  localparam int ADDR_STAT = 17;
  localparam int ADDR_MODE = 18;
  localparam int ADDR_CTL  = 19;
  localparam int CTL_EN    = 0;
  localparam int CTL_SER   = 1;
  localparam int CTL_PP    = 3;
  localparam logic [7:0] VERSION = 8'h5C;
endpackage

// File: rtl/dor_regs.sv
module dor_regs
  import dor_pkg::*;
#(
  parameter int P_NCH  = NCH,
  parameter int P_NG   = NGATED,
  parameter int P_SELW = SELW,
  localparam int MODEW = 2 * P_NG
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [AW-1:0]             bus_addr,
  input  logic [DW-1:0]             bus_wdata,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [MODEW-1:0]          drv_status,
  output logic [DW-1:0]             bus_rdata,
  output logic [P_NCH*P_SELW-1:0]   sel_flat,
  output logic [P_NCH-1:0]          sw_val,
  output logic [P_NCH-1:0]          sw_mask,
  output logic [MODEW-1:0]          mode_word,
  output logic                      ctl_en,
  output logic                      ctl_pp
);
  logic [P_SELW-1:0] sel_q [P_NCH];
  logic [DW-1:0]     rd_mux;
  logic              unused_wbits;

  assign unused_wbits = ^{bus_wdata[DW-1:MASK_LSB+P_NCH],
                          bus_wdata[MASK_LSB-1:P_NCH]};

  genvar gi;
  generate
    for (gi = 0; gi < P_NCH; gi++) begin : g_sel
      always_ff @(posedge clk) begin
        if (!rst_n)
          sel_q[gi] <= '0;
        else if (bus_wr && bus_addr == AW'(gi))
          sel_q[gi] <= bus_wdata[P_SELW-1:0];
      end
      assign sel_flat[gi*P_SELW +: P_SELW] = sel_q[gi];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_val    <= '0;
      sw_mask   <= '0;
      mode_word <= '0;
      ctl_en    <= 1'b0;
      ctl_pp    <= 1'b0;
    end else if (bus_wr) begin
      case (bus_addr)
        AW'(ADDR_CFG): begin
          sw_val  <= bus_wdata[P_NCH-1:0];
          sw_mask <= bus_wdata[MASK_LSB +: P_NCH];
        end
        AW'(ADDR_MODE): mode_word <= bus_wdata[MODEW-1:0];
        AW'(ADDR_CTL): begin
          ctl_en <= bus_wdata[CTL_EN];
          ctl_pp <= bus_wdata[CTL_PP];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      AW'(0):         rd_mux[7:0] = VERSION;
      AW'(ADDR_CFG): begin
        rd_mux[P_NCH-1:0]          = sw_val;
        rd_mux[MASK_LSB +: P_NCH]  = sw_mask;
      end
      AW'(ADDR_STAT): rd_mux[MODEW-1:0] = drv_status;
      AW'(ADDR_MODE): rd_mux[MODEW-1:0] = mode_word;
      AW'(ADDR_CTL): begin
        rd_mux[CTL_EN]  = ctl_en;
        rd_mux[CTL_SER] = 1'b0;
        rd_mux[CTL_PP]  = ctl_pp;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/dor_route.sv
module dor_route
  import dor_pkg::*;
#(
  parameter int P_NCH  = NCH,
  parameter int P_NG   = NGATED,
  parameter int P_SELW = SELW,
  localparam int P_BUSW = 1 << P_SELW
) (
  input  logic [P_BUSW-1:0]         sig_bus,
  input  logic [P_NCH*P_SELW-1:0]   sel_flat,
  input  logic [P_NCH-1:0]          sw_val,
  input  logic [P_NCH-1:0]          sw_mask,
  input  logic                      ctl_en,
  output logic [P_NCH-1:0]          chan_out
);
  genvar gc;
  generate
    for (gc = 0; gc < P_NCH; gc++) begin : g_ch
      logic routed;
      logic picked;
      assign routed = sig_bus[sel_flat[gc*P_SELW +: P_SELW]];
      assign picked = sw_mask[gc] ? sw_val[gc] : routed;
      if (gc < P_NG) begin : g_gated
        assign chan_out[gc] = ctl_en & picked;
      end else begin : g_free
        assign chan_out[gc] = picked;
      end
    end
  endgenerate
endmodule

// File: rtl/dor_mode.sv
module dor_mode
  import dor_pkg::*;
#(
  parameter int P_NG = NGATED,
  localparam int MODEW = 2 * P_NG
) (
  input  logic [MODEW-1:0] mode_word,
  input  logic             ctl_pp,
  input  logic [MODEW-1:0] drv_status,
  output logic [P_NG-1:0]  drv_pushpull,
  output logic [P_NG-1:0]  drv_openload,
  output logic [P_NG-1:0]  stat_undef,
  output logic [P_NG-1:0]  stat_uvlo
);
  genvar gm;
  generate
    for (gm = 0; gm < P_NG; gm++) begin : g_m
      logic pp_eff, fault, state;
      assign pp_eff            = ctl_pp | mode_word[gm];
      assign drv_pushpull[gm]  = pp_eff;
      assign drv_openload[gm]  = mode_word[gm + P_NG] & ~pp_eff;
      assign fault             = drv_status[gm + P_NG];
      assign state             = drv_status[gm];
      assign stat_undef[gm]    = fault & ~state;
      assign stat_uvlo[gm]     = fault & state;
    end
  endgenerate
endmodule

// File: rtl/dor_router.sv
module dor_router
  import dor_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DW-1:0]     bus_rdata,
  input  logic [BUSW-1:0]   sig_bus,
  input  logic [2*NGATED-1:0] drv_status,
  output logic [NCH-1:0]    chan_out,
  output logic [NGATED-1:0] drv_pushpull,
  output logic [NGATED-1:0] drv_openload,
  output logic              drv_enable,
  output logic [NGATED-1:0] stat_undef,
  output logic [NGATED-1:0] stat_uvlo
);
  logic [NCH*SELW-1:0]   sel_flat;
  logic [NCH-1:0]        sw_val, sw_mask;
  logic [2*NGATED-1:0]   mode_word;
  logic                  ctl_en, ctl_pp;

  dor_regs #(.P_NCH(NCH), .P_NG(NGATED), .P_SELW(SELW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .drv_status(drv_status),
    .bus_rdata(bus_rdata), .sel_flat(sel_flat), .sw_val(sw_val),
    .sw_mask(sw_mask), .mode_word(mode_word), .ctl_en(ctl_en), .ctl_pp(ctl_pp)
  );

  dor_route #(.P_NCH(NCH), .P_NG(NGATED), .P_SELW(SELW)) u_route (
    .sig_bus(sig_bus), .sel_flat(sel_flat), .sw_val(sw_val),
    .sw_mask(sw_mask), .ctl_en(ctl_en), .chan_out(chan_out)
  );

  dor_mode #(.P_NG(NGATED)) u_mode (
    .mode_word(mode_word), .ctl_pp(ctl_pp), .drv_status(drv_status),
    .drv_pushpull(drv_pushpull), .drv_openload(drv_openload),
    .stat_undef(stat_undef), .stat_uvlo(stat_uvlo)
  );

  assign drv_enable = ctl_en;
endmodule

// File: rtl/dor_chk.sv
module dor_chk
  import dor_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [AW-1:0]     bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DW-1:0]     bus_rdata,
  input logic [2*NGATED-1:0] drv_status,
  input logic [NCH-1:0]    chan_out,
  input logic [NGATED-1:0] drv_pushpull,
  input logic [NGATED-1:0] drv_openload,
  input logic              drv_enable,
  input logic              ctl_pp
);
  a_r2_bypass_next: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(ADDR_CFG) && bus_wdata[MASK_LSB+NCH-1])
      |=> chan_out[NCH-1] == $past(bus_wdata[NCH-1]));

  a_r3_gated_low: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_enable |-> chan_out[NGATED-1:0] == '0);

  a_r4_ol_excl: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_openload & drv_pushpull) == '0);

  a_r5_pp_force: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_pp |-> (&drv_pushpull) && drv_openload == '0);

  a_r6_ser_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == AW'(ADDR_CTL)) |=> bus_rdata[2:1] == 2'b00);

  a_r7_stat_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == AW'(ADDR_STAT))
      |=> bus_rdata[2*NGATED-1:0] == $past(drv_status));

  a_r8_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == AW'(20)) |=> bus_rdata == '0);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind dor_router dor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .drv_status(drv_status), .chan_out(chan_out), .drv_pushpull(drv_pushpull),
  .drv_openload(drv_openload), .drv_enable(drv_enable), .ctl_pp(ctl_pp)
);

// File: tb/tb_dor_router.sv
module tb_dor_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [255:0] sig_bus = '0;
  logic [15:0] drv_status = '0;
  logic [9:0]  chan_out;
  logic [7:0]  drv_pushpull, drv_openload, stat_undef, stat_uvlo;
  logic        drv_enable;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dor_router dut (.*);

  // {addr, write data, expected read-back}
  localparam logic [68:0] VEC [8] = '{
    {5'd16, 32'hFFFF_FFFF, 32'h03FF_03FF},   // R2
    {5'd18, 32'h1234_A5C3, 32'h0000_A5C3},   // R4
    {5'd19, 32'hFFFF_FFFF, 32'h0000_0009},   // R6
    {5'd19, 32'h0000_0006, 32'h0000_0000},   // R6
    {5'd5,  32'h0000_00AB, 32'h0000_0000},   // R8 write-only selector
    {5'd0,  32'h0000_0077, 32'h0000_005C},   // R8 version
    {5'd25, 32'hFFFF_FFFF, 32'h0000_0000},   // R8 unmapped
    {5'd16, 32'h0155_02AA, 32'h0155_02AA}    // R2
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [9:0] exp_o;
    for (int j = 0; j < 256; j++) sig_bus[j] = j[0] ^ j[3] ^ j[6];
    sig_bus[0] = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 chan_out", {22'd0, chan_out}, {22'd0, 2'b11, 8'h00});
    chk("R10 drivers", {15'd0, drv_enable, drv_pushpull, drv_openload}, 32'd0);
    chk("R10 rdata", bus_rdata, 32'd0);
    rd(5'd16, r); chk("R10 cfg", r, 32'd0);
    rd(5'd18, r); chk("R10 mode", r, 32'd0);
    rd(5'd19, r); chk("R10 ctl", r, 32'd0);

    for (int v = 0; v < 8; v++) begin
      wr(VEC[v][68:64], VEC[v][63:32]);
      rd(VEC[v][68:64], r);
      chk("vector table", r, VEC[v][31:0]);
    end

    // R1 routing
    wr(5'd16, 32'h0); wr(5'd19, 32'h1);
    for (int c = 0; c < 10; c++) wr(5'(c), 32'(17 * c + 3));
    for (int c = 0; c < 10; c++) exp_o[c] = sig_bus[17 * c + 3];
    chk("R1 route", {22'd0, chan_out}, {22'd0, exp_o});
    @(negedge clk); sig_bus = ~sig_bus; @(negedge clk);
    chk("R1 follow", {22'd0, chan_out}, {22'd0, ~exp_o});
    // R1 timing: new selector visible the cycle after the write edge
    @(negedge clk); bus_addr = 5'd9; bus_wdata = 32'd0; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    chk("R1 next cycle", {31'd0, chan_out[9]}, {31'd0, sig_bus[0]});

    // R2 bypass
    wr(5'd16, 32'h03FF_0155);
    chk("R2 all bypass", {22'd0, chan_out}, 32'h155);
    wr(5'd16, 32'h000F_03FF);
    for (int c = 0; c < 10; c++) exp_o[c] = (c < 4) ? 1'b1 : sig_bus[(c == 9) ? 0 : 17 * c + 3];
    chk("R2 partial", {22'd0, chan_out}, {22'd0, exp_o});

    // R3 enable
    wr(5'd16, 32'h03FF_03FF); wr(5'd19, 32'h0);
    chk("R3 gated", {22'd0, chan_out}, 32'h300);
    chk("R3 drv_enable", {31'd0, drv_enable}, 32'd0);

    // R4 mode
    wr(5'd18, 32'h0F3C); wr(5'd19, 32'h1);
    chk("R4 pushpull", {24'd0, drv_pushpull}, 32'h3C);
    chk("R4 openload", {24'd0, drv_openload}, 32'h03);

    // R5 global push-pull
    wr(5'd19, 32'h9);
    chk("R5 pushpull", {24'd0, drv_pushpull}, 32'hFF);
    chk("R5 openload", {24'd0, drv_openload}, 32'h00);
    rd(5'd18, r); chk("R5 mode kept", r, 32'h0F3C);

    // R7 status
    drv_status = 16'hC3A5;
    @(negedge clk);
    chk("R7 undef", {24'd0, stat_undef}, 32'h42);
    chk("R7 uvlo", {24'd0, stat_uvlo}, 32'h81);
    rd(5'd17, r); chk("R7 read", r, 32'hC3A5);
    wr(5'd17, 32'h0);
    rd(5'd17, r); chk("R7 write ignored", r, 32'hC3A5);
    rd(5'd16, r); chk("R7 cfg untouched", r, 32'h03FF_03FF);
    rd(5'd19, r); chk("R7 ctl untouched", r, 32'h9);

    // R9 hold and read-before-write
    @(negedge clk); bus_addr = 5'd0;
    repeat (3) @(negedge clk);
    chk("R9 hold", bus_rdata, 32'h9);
    @(negedge clk); bus_addr = 5'd18; bus_wdata = 32'h0001; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk); bus_wr = 1'b0; bus_rd = 1'b0;
    chk("R9 old value", bus_rdata, 32'h0F3C);
    rd(5'd18, r); chk("R9 new value", r, 32'h0001);
    rd(5'd3, r); chk("R8 sel read zero", r, 32'h0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule